// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular ring of transmit descriptors held in host memory. It uses one request/response memory port. Each descriptor is a single word that carries an ownership flag, a start-of-frame flag, an end-of-frame flag, three status flags and a buffer length counted in data words. When the engine owns a descriptor, it fetches that descriptor's buffer words and pushes them toward a transmit FIFO. While it does this, it reads the following descriptor ahead of time. When the work is done, it returns each descriptor to the host by writing it back with ownership cleared and any error flags set.

Idle polling is paced by a programmable poll timer. After every transmit operation the engine polls the next descriptor at once, so frames that are already queued run back to back. The engine has three fault paths:
- A chained frame whose next buffer is not ready is an underflow. The engine either stops transmitting until it is re-initialised, or recovers and keeps polling. A mode input selects which.
- An error reported during transmission ends the frame.
- After an error, the remaining middle buffers of that frame are handed back to the host unused.

Descriptor word layout, with `DW` as the word width: bit DW-1 ownership, DW-2 start-of-frame, DW-3 end-of-frame, DW-4 transmit error, DW-5 buffer error, DW-6 underflow. Bits [LEN_W-1:0] hold the length. Memory addresses are `{0, zeros, index}` for descriptor `index` and `{1, index, word}` for word `word` of that descriptor's buffer.

Top module: `tdr_tx_ring`

## Requirements
- R1: Out of reset the ring index is 0 and the engine is idle. `tx_on` is 1, with no memory request and no FIFO push.
- R2: While idle, the engine reads only the descriptor at the current index, once every `poll_interval`+1 idle cycles. A descriptor with ownership 0 returns the engine to idle with the timer restarted.
- R3: A descriptor with ownership 1 and start-of-frame 1 starts a transfer. Buffer words are read in order, and each read is issued only while `fifo_ready` is 1. Each word is pushed with `fifo_valid`. `fifo_last` marks the final word of a buffer that has end-of-frame 1.
- R4: For a buffer with end-of-frame 0, the next descriptor is read only after the first word of the current buffer has been transferred, or at once if the buffer length is 0.
- R5: When the next descriptor is owned, the current descriptor is written back with ownership 0 after its last word, and transfer continues with the next buffer. A buffer with end-of-frame 1 is written back only after its final word.
- R6: If the looked-ahead descriptor has ownership 0, the current buffer is finished and then written back with buffer error and underflow set. With `recover_en` 0, `tx_on` then drops and no data is fetched until a `tx_init` pulse, which restarts the ring at index 0.
- R7: With `recover_en` 1, an underflow does not stop the engine. It polls onward from the next index.
- R8: On a `tx_err` during transfer, word fetching stops once the outstanding read completes. The current descriptor is written back with the transmit error flag set. Each following descriptor that is owned and has start-of-frame 0 is then written back with only ownership cleared. The scan stops at a descriptor that is not owned or that has start-of-frame 1.
- R9: An owned zero-length buffer is written back with ownership 0 and no data fetched. When it is the last buffer of a chain (start-of-frame 0, end-of-frame 1), buffer error is also set.
- R10: After every write-back that ends an operation, the next descriptor is polled at once with no timer wait, so a queued frame follows immediately.
- R11: The ring index wraps from `RING_DEPTH`-1 to 0. `RING_DEPTH` is a power of two.
- R12: A memory request keeps its address, direction and write data stable until acknowledged. Every descriptor write has ownership 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_init | input | 1 | Re-initialise pulse; leaves the disabled state and resets the index |
| recover_en | input | 1 | 1: continue after underflow; 0: disable the transmitter |
| poll_interval | input | TMR_W | Idle cycles between polls, minus one |
| tx_err | input | 1 | Transmit error report from the MAC side |
| fifo_ready | input | 1 | FIFO can accept a word |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a descriptor write-back |
| mem_addr | output | AW | Descriptor or buffer word address |
| mem_wdata | output | DW | Write-back descriptor word |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| fifo_valid | output | 1 | Buffer word push |
| fifo_data | output | DW | Pushed word |
| fifo_last | output | 1 | Final word of a frame |
| tx_on | output | 1 | Transmitter enabled |

## Verification
The bench builds the block with an 8-entry ring, 4-bit buffer lengths, 32-bit words and an 8-bit timer, with the poll interval set to 60. The short ring lets one run cover a pass through every index and the wrap back to 0. The 60-cycle interval is much longer than a back-to-back frame gap, so an immediate re-poll can be told apart from a timer-paced poll. Short buffers keep lookahead, underflow, error skipping and zero-length cases within a few words each.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_POLL,
      ST_DATA,
      ST_LOOK,
      ST_STAT,
      ST_CLR,
      ST_HALT
   } tdr_state_e;

   // flag positions, counted down from the descriptor MSB
   localparam int FLG_OWN = 0;
   localparam int FLG_SOF = 1;
   localparam int FLG_EOF = 2;
   localparam int FLG_ERR = 3;
   localparam int FLG_BUF = 4;
   localparam int FLG_UFL = 5;
   localparam int FLG_NUM = 6;

endpackage

// File: rtl/tdr_poll_timer.sv
module tdr_poll_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TMR_W-1:0] interval,
   output logic             fire
);
   logic [TMR_W-1:0] cnt;

   assign fire = run && (cnt == interval);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || fire)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tdr_ring_ptr.sv
module tdr_ring_ptr #(
   parameter int RING_DEPTH = 16,
   parameter int IW         = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   output logic [IW-1:0] idx,
   output logic [IW-1:0] idx_nx
);
   generate
      if (RING_DEPTH == 1) begin : g_single
         assign idx    = '0;
         assign idx_nx = '0;
      end else begin : g_ring
         logic [IW-1:0] p;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               p <= '0;
            else if (clr)
               p <= '0;
            else if (adv)
               p <= p + 1'b1;
         end
         assign idx    = p;
         assign idx_nx = p + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/tdr_tx_ring.sv
module tdr_tx_ring
   import tdr_pkg::*;
#(
   parameter int DW         = 32,
   parameter int RING_DEPTH = 16,
   parameter int LEN_W      = 8,
   parameter int TMR_W      = 16,
   localparam int IW        = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1,
   localparam int AW        = 1 + IW + LEN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_init,
   input  logic             recover_en,
   input  logic [TMR_W-1:0] poll_interval,
   input  logic             tx_err,
   input  logic             fifo_ready,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ack,
   input  logic [DW-1:0]    mem_rdata,
   output logic             fifo_valid,
   output logic [DW-1:0]    fifo_data,
   output logic             fifo_last,
   output logic             tx_on
);
   localparam int B_OWN = DW - 1 - FLG_OWN;
   localparam int B_SOF = DW - 1 - FLG_SOF;
   localparam int B_EOF = DW - 1 - FLG_EOF;
   localparam int B_ERR = DW - 1 - FLG_ERR;
   localparam int B_BUF = DW - 1 - FLG_BUF;
   localparam int B_UFL = DW - 1 - FLG_UFL;

   generate
      if (DW < LEN_W + FLG_NUM) begin : g_bad_width
         $error("descriptor word too narrow for length and flags");
      end
      if (RING_DEPTH < 1 || (RING_DEPTH & (RING_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ring depth must be a power of two");
      end
      if (TMR_W < 1) begin : g_bad_tmr
         $error("timer width must be positive");
      end
   endgenerate

   tdr_state_e       state;
   logic [DW-1:0]    cur, look;
   logic [LEN_W-1:0] beat, cur_len;
   logic             look_done, uflo_pend, err_pend, dreq;
   logic [IW-1:0]    idx, idx_nx;
   logic             fire, ack_ok, adv, need_look, zero_last;
   logic [DW-1:0]    stat_word;

   assign cur_len   = cur[LEN_W-1:0];
   assign ack_ok    = mem_req && mem_ack;
   assign need_look = !cur[B_EOF] && !look_done && (beat != '0 || cur_len == '0);
   assign zero_last = (cur_len == '0) && !cur[B_SOF] && cur[B_EOF];
   assign tx_on     = (state != ST_HALT);

   always_comb begin
      stat_word        = cur;
      stat_word[B_OWN] = 1'b0;
      if (err_pend)  stat_word[B_ERR] = 1'b1;
      if (uflo_pend) begin
         stat_word[B_BUF] = 1'b1;
         stat_word[B_UFL] = 1'b1;
      end
      if (zero_last) stat_word[B_BUF] = 1'b1;
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = {1'b0, {LEN_W{1'b0}}, idx};
      mem_wdata = '0;
      unique case (state)
         ST_POLL: mem_req = 1'b1;
         ST_LOOK: begin
            mem_req  = 1'b1;
            mem_addr = {1'b0, {LEN_W{1'b0}}, idx_nx};
         end
         ST_DATA: begin
            mem_req  = dreq;
            mem_addr = {1'b1, idx, beat};
         end
         ST_STAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = stat_word;
         end
         ST_CLR: begin
            mem_req          = 1'b1;
            mem_we           = 1'b1;
            mem_wdata        = cur;
            mem_wdata[B_OWN] = 1'b0;
         end
         default: ;
      endcase
   end

   assign adv = ack_ok && ((state == ST_CLR) ||
                (state == ST_STAT && !(uflo_pend && !err_pend && !recover_en)));

   tdr_ring_ptr #(.RING_DEPTH(RING_DEPTH), .IW(IW)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (state == ST_HALT && tx_init),
      .adv    (adv),
      .idx    (idx),
      .idx_nx (idx_nx)
   );

   tdr_poll_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state == ST_IDLE),
      .interval (poll_interval),
      .fire     (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cur        <= '0;
         look       <= '0;
         beat       <= '0;
         look_done  <= 1'b0;
         uflo_pend  <= 1'b0;
         err_pend   <= 1'b0;
         dreq       <= 1'b0;
         fifo_valid <= 1'b0;
         fifo_data  <= '0;
         fifo_last  <= 1'b0;
      end else begin
         fifo_valid <= 1'b0;
         fifo_last  <= 1'b0;
         if ((state == ST_DATA || state == ST_LOOK) && tx_err)
            err_pend <= 1'b1;
         unique case (state)
            ST_IDLE: if (fire) state <= ST_POLL;
            ST_POLL: if (ack_ok) begin
               cur       <= mem_rdata;
               beat      <= '0;
               look_done <= 1'b0;
               if (mem_rdata[B_OWN] && mem_rdata[B_SOF]) state <= ST_DATA;
               else if (mem_rdata[B_OWN])                state <= ST_CLR;
               else                                      state <= ST_IDLE;
            end
            ST_DATA: begin
               if (dreq) begin
                  if (ack_ok) begin
                     dreq       <= 1'b0;
                     beat       <= beat + 1'b1;
                     fifo_valid <= 1'b1;
                     fifo_data  <= mem_rdata;
                     fifo_last  <= cur[B_EOF] && (beat + 1'b1 == cur_len);
                  end
               end else if (err_pend || tx_err) begin
                  err_pend <= 1'b1;
                  state    <= ST_STAT;
               end else if (need_look) begin
                  state <= ST_LOOK;
               end else if (beat == cur_len) begin
                  state <= ST_STAT;
               end else if (fifo_ready) begin
                  dreq <= 1'b1;
               end
            end
            ST_LOOK: if (ack_ok) begin
               look      <= mem_rdata;
               look_done <= 1'b1;
               if (!mem_rdata[B_OWN]) uflo_pend <= 1'b1;
               state     <= ST_DATA;
            end
            ST_STAT: if (ack_ok) begin
               if (err_pend) begin
                  err_pend  <= 1'b0;
                  uflo_pend <= 1'b0;
                  state     <= ST_POLL;
               end else if (uflo_pend) begin
                  uflo_pend <= 1'b0;
                  state     <= recover_en ? ST_POLL : ST_HALT;
               end else if (cur[B_EOF]) begin
                  state <= ST_POLL;
               end else begin
                  cur       <= look;
                  beat      <= '0;
                  look_done <= 1'b0;
                  state     <= ST_DATA;
               end
            end
            ST_CLR:  if (ack_ok) state <= ST_POLL;
            ST_HALT: if (tx_init) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tdr_tx_ring_chk.sv
module tdr_tx_ring_chk #(
   parameter int DW = 32,
   parameter int AW = 13
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tx_init,
   input logic          tx_on,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          fifo_valid,
   input logic          fifo_last
);
   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   p_wr_own_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !mem_wdata[DW-1]);

   p_wr_desc_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !mem_addr[AW-1]);

   p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_on && !tx_init |=> !tx_on);

   p_no_fetch_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_on |-> !(mem_req && mem_addr[AW-1]));

   p_last_with_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_last |-> fifo_valid);
endmodule

bind tdr_tx_ring tdr_tx_ring_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_init    (tx_init),
   .tx_on      (tx_on),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_ack    (mem_ack),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .fifo_valid (fifo_valid),
   .fifo_last  (fifo_last)
);

// File: tb/tdr_tx_ring_bench.sv
`timescale 1ns/1ps
module tdr_tx_ring_bench;
   localparam int DW = 32, RD = 8, LW = 4, TW = 8;
   localparam int IW = 3, AW = 1 + IW + LW;
   localparam int OWN = 31, SOF = 30, EOF = 29, ERR = 28, BUF = 27, UFL = 26;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, tx_init, recover_en, tx_err, fifo_ready, mem_ack;
   logic [TW-1:0] poll_interval;
   logic [DW-1:0] mem_rdata;
   logic mem_req, mem_we, fifo_valid, fifo_last, tx_on;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, fifo_data;

   tdr_tx_ring #(.DW(DW), .RING_DEPTH(RD), .LEN_W(LW), .TMR_W(TW)) u_tdr_tx_ring (
      .clk(clk), .rst_n(rst_n), .tx_init(tx_init), .recover_en(recover_en),
      .poll_interval(poll_interval), .tx_err(tx_err), .fifo_ready(fifo_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fifo_valid(fifo_valid),
      .fifo_data(fifo_data), .fifo_last(fifo_last), .tx_on(tx_on));

   logic [DW-1:0] desc [RD];
   int checks = 0, errors = 0, seq = 0, cyc = 0;
   int first_data [RD], last_data [RD], rd_seq [RD], wr_seq [RD], rd_cnt [RD];
   typedef struct packed { logic [DW-1:0] d; logic l; } item_t;
   item_t exp_q [$];
   bit sb_off = 0;
   int loose_items = 0, last_t = 0, prev_t = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DW-1:0] dval(int idx, int b);
      return 32'hD000_0000 | (idx << 8) | b;
   endfunction

   function automatic logic [DW-1:0] mk(bit own, bit sof, bit eof, int len);
      return ({own, sof, eof} << 29) | len;
   endfunction

   task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic push_frame(int idx, int n, bit last);
      for (int b = 0; b < n; b++) exp_q.push_back({dval(idx, b), last && (b == n - 1)});
   endtask

   task automatic clear_logs();
      for (int i = 0; i < RD; i++) begin
         first_data[i] = -1; last_data[i] = -1; rd_seq[i] = -1; wr_seq[i] = -1; rd_cnt[i] = 0;
      end
   endtask

   task automatic wait_released(int idx);
      for (int i = 0; i < 3000 && desc[idx][OWN]; i++) @(negedge clk);
   endtask

   task automatic wait_idle_q();
      for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
      repeat (20) @(negedge clk);
   endtask

   // memory model: one request at a time, acknowledged after one wait cycle
   initial begin
      int lat;
      int ix;
      lat = 0; mem_ack = 1'b0; mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_ack) mem_ack = 1'b0;
         else if (rst_n && mem_req) begin
            if (lat == 1) begin
               lat = 0; seq++;
               if (mem_addr[AW-1]) begin
                  ix = int'(mem_addr[AW-2:LW]);
                  mem_rdata = dval(ix, int'(mem_addr[LW-1:0]));
                  if (first_data[ix] < 0) first_data[ix] = seq;
                  last_data[ix] = seq;
               end else begin
                  ix = int'(mem_addr[IW-1:0]);
                  if (mem_we) begin desc[ix] = mem_wdata; wr_seq[ix] = seq; end
                  else begin mem_rdata = desc[ix]; rd_seq[ix] = seq; rd_cnt[ix]++; end
               end
               mem_ack = 1'b1;
            end else lat++;
         end
      end
   end

   // scoreboard monitor
   initial begin
      item_t e;
      forever begin
         @(negedge clk);
         if (rst_n && fifo_valid) begin
            prev_t = last_t; last_t = cyc;
            if (sb_off) loose_items++;
            else if (exp_q.size() == 0)
               check(0, "R3", fifo_data, '0, "unexpected FIFO word");
            else begin
               e = exp_q.pop_front();
               check(fifo_data == e.d && fifo_last == e.l, "R3",
                     {fifo_data[DW-2:0], fifo_last}, {e.d[DW-2:0], e.l}, "FIFO word/last");
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] w;
      int n;
      for (int i = 0; i < RD; i++) desc[i] = '0;
      clear_logs();
      rst_n = 0; tx_init = 0; recover_en = 1; tx_err = 0; fifo_ready = 1; poll_interval = 8'd60;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(tx_on == 1'b1, "R1", DW'(tx_on), 1, "tx_on after reset");
      check(mem_req == 1'b0, "R1", DW'(mem_req), 0, "no request after reset");
      check(fifo_valid == 1'b0, "R1", DW'(fifo_valid), 0, "no push after reset");

      // R2 idle polling of index 0 only
      repeat (320) @(negedge clk);
      check(rd_cnt[0] >= 4 && rd_cnt[0] <= 6, "R2", rd_cnt[0], 5, "idle polls of index 0");
      n = 0; for (int i = 1; i < RD; i++) n += rd_cnt[i];
      check(n == 0, "R2", n, 0, "reads of other indices while idle");

      // R3 single frame with FIFO back-pressure
      clear_logs();
      fifo_ready = 0;
      w = mk(1, 1, 1, 3); desc[0] = w; push_frame(0, 3, 1);
      repeat (150) @(negedge clk);
      check(first_data[0] < 0, "R3", first_data[0], -1, "no fetch while fifo_ready low");
      check(desc[0][OWN] == 1'b1, "R3", desc[0], w, "descriptor kept while stalled");
      fifo_ready = 1;
      wait_released(0); wait_idle_q();
      check(desc[0] == (w & ~(1 << OWN)), "R5", desc[0], w & ~(1 << OWN), "single frame write-back");
      check(exp_q.size() == 0, "R3", exp_q.size(), 0, "all words of frame 0 seen");

      // R4 R5 R9 chain 1,2(zero length),3 with lookahead
      clear_logs();
      desc[3] = mk(1, 0, 1, 2); desc[2] = mk(1, 0, 0, 0); desc[1] = mk(1, 1, 0, 2);
      push_frame(1, 2, 0); push_frame(3, 2, 1);
      wait_released(3); wait_idle_q();
      check(rd_seq[2] > first_data[1] && first_data[1] > 0, "R4", rd_seq[2], first_data[1], "lookahead after first word");
      check(wr_seq[1] < first_data[3], "R5", wr_seq[1], first_data[3], "chained write-back before next buffer");
      check(wr_seq[3] > last_data[3], "R5", wr_seq[3], last_data[3], "last buffer released after final word");
      check(desc[2] == mk(0, 0, 0, 0), "R9", desc[2], mk(0, 0, 0, 0), "zero-length middle buffer released");
      check(desc[1] == mk(0, 1, 0, 2), "R5", desc[1], mk(0, 1, 0, 2), "first buffer clean write-back");

      // R10 back-to-back frames 4 and 5
      desc[5] = mk(1, 1, 1, 1); desc[4] = mk(1, 1, 1, 1);
      push_frame(4, 1, 1); push_frame(5, 1, 1);
      wait_released(5); wait_idle_q();
      check(last_t - prev_t < 30, "R10", last_t - prev_t, 30, "gap between queued frames");

      // R6 R7 underflow with recovery at index 6
      clear_logs();
      desc[7] = '0; desc[6] = mk(1, 1, 0, 2); push_frame(6, 2, 0);
      wait_released(6); wait_idle_q();
      check(desc[6] == (mk(0, 1, 0, 2) | (1 << BUF) | (1 << UFL)), "R6", desc[6],
            mk(0, 1, 0, 2) | (1 << BUF) | (1 << UFL), "underflow status");
      check(tx_on == 1'b1, "R7", DW'(tx_on), 1, "transmitter on after recovery");
      desc[7] = mk(1, 1, 1, 1); push_frame(7, 1, 1);
      wait_released(7); wait_idle_q();
      check(desc[7] == mk(0, 1, 1, 1), "R7", desc[7], mk(0, 1, 1, 1), "polling resumed at next index");
      desc[0] = mk(1, 1, 1, 1); push_frame(0, 1, 1);
      wait_released(0); wait_idle_q();
      check(desc[0] == mk(0, 1, 1, 1), "R11", desc[0], mk(0, 1, 1, 1), "ring wrapped to index 0");

      // R8 error at index 1, skip 2 and 3, stop at 4
      sb_off = 1; loose_items = 0;
      desc[3] = mk(1, 0, 1, 1); desc[2] = mk(1, 0, 0, 2); desc[1] = mk(1, 1, 0, 4);
      for (int i = 0; i < 3000 && loose_items == 0; i++) @(negedge clk);
      tx_err = 1;
      wait_released(1);
      tx_err = 0;
      wait_released(3);
      repeat (30) @(negedge clk);
      sb_off = 0;
      check(desc[1] == (mk(0, 1, 0, 4) | (1 << ERR)), "R8", desc[1], mk(0, 1, 0, 4) | (1 << ERR), "errored buffer status");
      check(desc[2] == mk(0, 0, 0, 2), "R8", desc[2], mk(0, 0, 0, 2), "middle buffer skipped");
      check(desc[3] == mk(0, 0, 1, 1), "R8", desc[3], mk(0, 0, 1, 1), "last buffer skipped");
      check(loose_items >= 1 && loose_items < 4, "R8", loose_items, 1, "words sent before stop");
      check(desc[4] == mk(0, 1, 1, 1), "R8", desc[4], mk(0, 1, 1, 1), "scan stopped at unowned");

      // R6 underflow without recovery at index 4
      recover_en = 0;
      desc[4] = mk(1, 1, 0, 1); push_frame(4, 1, 0);
      wait_released(4); wait_idle_q();
      check(tx_on == 1'b0, "R6", DW'(tx_on), 0, "transmitter disabled");
      check(desc[4] == (mk(0, 1, 0, 1) | (1 << BUF) | (1 << UFL)), "R6", desc[4],
            mk(0, 1, 0, 1) | (1 << BUF) | (1 << UFL), "underflow status no recovery");
      desc[0] = mk(1, 1, 1, 1);
      repeat (200) @(negedge clk);
      check(desc[0][OWN] == 1'b1, "R6", desc[0], mk(1, 1, 1, 1), "no work while disabled");
      push_frame(0, 1, 1);
      tx_init = 1; @(negedge clk); tx_init = 0;
      wait_released(0); wait_idle_q();
      check(tx_on == 1'b1 && desc[0] == mk(0, 1, 1, 1), "R6", desc[0], mk(0, 1, 1, 1), "restart at index 0");

      // R9 zero-length last buffer of a chain
      desc[2] = mk(1, 0, 1, 0); desc[1] = mk(1, 1, 0, 1); push_frame(1, 1, 0);
      wait_released(2); wait_idle_q();
      check(desc[2] == (mk(0, 0, 1, 0) | (1 << BUF)), "R9", desc[2], mk(0, 0, 1, 0) | (1 << BUF), "zero-length last flagged");
      check(desc[1] == mk(0, 1, 0, 1), "R9", desc[1], mk(0, 1, 0, 1), "preceding buffer clean");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule